// File: doc/BRIEF.md
# Mailbox Request-Response Requester Engine

This block runs one data-object exchange against a register-mapped mailbox. It acts as the bus master. A caller gives it a protocol vendor ID, a protocol type, a request payload word count and a response buffer size, then pulses `start`.

The engine checks the mailbox status and writes the two header dwords and the payload into the write-data register. It then sets GO, polls for the response and reads the response object back one dword at a time. It acknowledges every dword it reads and keeps only as many payload words as the caller's buffer holds. Any surplus is drained and discarded.

Payload words are fetched from the caller through an index/data lookup port. Response words are handed back through a write port. The exchange ends with a one-cycle `done`, an error flag and the stored word count.

Any failure during an exchange makes the engine issue an abort to the mailbox and wait for the mailbox to come back clean. If that abort does not complete within the timeout, the engine marks itself dead. From then on it refuses every request at once, without touching the bus, until it is reset. The timeout and the poll interval (one 128th of the timeout) are counted in clock cycles.

Top module: `mbx_req_engine`

## Requirements
- R1: After reset, and whenever no exchange is running, `bus_req` and `done` stay low.
- R2: A normal exchange proceeds in this order:
  - a status read (address 1);
  - header dword one, carrying `{8'h00, type[23:16], vid[15:0]}`, written to address 2;
  - header dword two, carrying the length, written to address 2;
  - every payload word, in index order, written to address 2;
  - a write of bit 31 (GO) to the control register (address 0).
  After the response it pulses `done` for one cycle with `err`=0, and every stored word is delivered at its index.
- R3: The header length field, in bits [LEN_W-1:0], equals payload count plus 2. A length of exactly 2^LEN_W is sent as 0. A length above 2^LEN_W is refused before any header write, and that refusal goes through the abort path.
- R4: If the opening status read shows busy (bit 0) or error (bit 2), no header is written, an abort is issued (control bit 0), and the exchange ends with `err`=1.
- R5: After GO, status is read once every POLL_CYC cycles. An error bit during polling leads to an abort. If ready (bit 31) is not seen within TIMEOUT_CYC cycles, an abort follows. In both cases `err`=1, and in the timeout case `done` comes no earlier than TIMEOUT_CYC cycles after the start.
- R6: If the first response dword does not match the requested vendor ID and type, the exchange fails with an abort and `err`=1.
- R7: Every dword read from the read-data register (address 3) is acknowledged by writing 0 to address 3. Payload beyond the buffer size is read and acknowledged but not stored, so the whole object is consumed. `rsp_cnt` equals min(object length - 2, buffer size).
- R8: A received length field of 0 stands for 2^LEN_W dwords. A received length below 2 fails with an abort.
- R9: Before acknowledging the last stored word, the engine re-reads status. If ready is clear, the exchange fails with an abort and that last word is left unacknowledged.
- R10: After draining, status is read once more. A set error bit then fails the exchange with an abort.
- R11: An abort completes once status shows both busy and error clear. If it does not complete within TIMEOUT_CYC cycles, the engine becomes dead, and every later request ends with `err`=1 and no bus access until reset.
- R12: A request with a response buffer size of 0 ends on the next cycle with `err`=1, with no bus access and no abort.
- R13: Whenever `err`=1 at `done`, `rsp_cnt` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an exchange (taken when idle) |
| cmd_vid | input | 16 | Protocol vendor ID |
| cmd_type | input | 8 | Protocol type |
| cmd_req_cnt | input | LEN_W+1 | Request payload dword count |
| cmd_rsp_buf | input | LEN_W+1 | Response buffer size in dwords |
| req_rd_idx | output | LEN_W+1 | Index of the payload word being fetched |
| req_rd_data | input | 32 | Payload word at `req_rd_idx` (combinational) |
| rsp_wr_en | output | 1 | Response word strobe |
| rsp_wr_idx | output | LEN_W+1 | Response word index |
| rsp_wr_data | output | 32 | Response word |
| done | output | 1 | One-cycle end-of-exchange pulse |
| err | output | 1 | Exchange failed (valid with and after `done`) |
| rsp_cnt | output | LEN_W+1 | Response words stored |
| bus_req | output | 1 | Mailbox access request, held until `bus_ack` |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 2 | 0 control, 1 status, 2 write-data, 3 read-data |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access completes this cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
The bench builds the engine with LEN_W=6 and TIMEOUT_CYC=256, which gives a poll interval of 2 cycles. A 64-dword object then takes only a few hundred cycles. That brings two boundary cases within reach: the zero-encoded length on both the send side (62 payload words) and the receive side, and the refusal at 63 payload words. The short timeout lets both the poll timeout and the failed abort that leads to the dead state run to completion. The sweep covers every combination of 0 to 3 request words, 0 to 5 response payload words and buffer sizes 1 to 4, so both truncation and exact fit are exercised.

// File: rtl/mbx_pkg.sv
// Shared constants and state encoding for the mailbox requester.
// Assumes a 32-bit register bus with four word addresses.
package mbx_pkg;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_WDAT = 2'd2;
    localparam logic [1:0] A_RDAT = 2'd3;

    localparam int STAT_BUSY = 0;
    localparam int STAT_ERR  = 2;
    localparam int STAT_RDY  = 31;
    localparam int CTL_ABORT = 0;
    localparam int CTL_GO    = 31;

    typedef enum logic [4:0] {
        S_IDLE, S_PRECHK, S_HDR1, S_HDR2, S_PAY, S_GO,
        S_POLL_RD, S_POLL_WAIT, S_RX_H1, S_RX_A1, S_RX_H2, S_RX_A2,
        S_RX_RD, S_RX_CHK, S_RX_ACK, S_FIN_RD,
        S_AB_WR, S_AB_WAIT, S_AB_RD
    } mbx_state_e;
endpackage

// File: rtl/mbx_len.sv
// Length arithmetic: encodes the outgoing object length, decodes the
// incoming one and works out how many payload words to keep.
// Assumes all inputs are registered by the caller.
module mbx_len #(
    parameter int LEN_W = 18,
    parameter int CW    = LEN_W + 1
) (
    input  logic [CW-1:0]    req_cnt,
    input  logic [CW-1:0]    rsp_buf,
    input  logic [LEN_W-1:0] rx_field,
    output logic             too_long,
    output logic [LEN_W-1:0] tx_field,
    output logic             rx_short,
    output logic [CW-1:0]    rx_rem,
    output logic [CW-1:0]    keep_n
);
    localparam int unsigned MAXLEN = 1 << LEN_W;

    logic [CW:0]   obj_len;
    logic [CW-1:0] rx_len;

    // Outgoing length: two header dwords plus payload; the top value wraps to 0.
    always_comb begin
        obj_len  = {1'b0, req_cnt} + (CW+1)'(2);
        too_long = obj_len > (CW+1)'(MAXLEN);
        tx_field = obj_len[LEN_W-1:0];
    end

    // Incoming length: zero means the maximum; keep at most the buffer size.
    always_comb begin
        rx_len   = (rx_field == '0) ? CW'(MAXLEN) : CW'(rx_field);
        rx_short = rx_len < CW'(2);
        rx_rem   = rx_short ? '0 : rx_len - CW'(2);
        keep_n   = (rx_rem < rsp_buf) ? rx_rem : rsp_buf;
    end
endmodule

// File: rtl/mbx_tmr.sv
// Timeout and poll-interval counters shared by the poll and abort phases.
// Assumes clr starts a new timed phase and ivl_clr starts a new wait.
module mbx_tmr #(
    parameter int TIMEOUT_CYC = 1000,
    parameter int POLL_CYC    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ivl_clr,
    output logic expired,
    output logic poll_due
);
    localparam int EW = $clog2(TIMEOUT_CYC + 2) + 1;
    localparam int IW = $clog2(POLL_CYC + 1) + 1;

    logic [EW-1:0] elapsed_q;
    logic [IW-1:0] ivl_q;

    assign expired  = elapsed_q > EW'(TIMEOUT_CYC);
    assign poll_due = ivl_q >= IW'(POLL_CYC - 1);

    // Phase age, saturating once past the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  elapsed_q <= '0;
        else if (!expired)  elapsed_q <= elapsed_q + EW'(1);
    end

    // Cycles since the last status read, saturating at the interval.
    always_ff @(posedge clk) begin
        if (!rst_n || ivl_clr) ivl_q <= '0;
        else if (!poll_due)    ivl_q <= ivl_q + IW'(1);
    end
endmodule

// File: rtl/mbx_req_engine.sv
// Mailbox requester: runs send, poll, receive, drain and abort for one
// exchange at a time and locks itself dead when an abort cannot finish.
// Assumes the responder holds bus_rdata valid in the bus_ack cycle and that
// the command inputs stay stable from start until done.
module mbx_req_engine
    import mbx_pkg::*;
#(
    parameter int LEN_W       = 18,
    parameter int TIMEOUT_CYC = 200_000_000,
    parameter int CW          = LEN_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [15:0]   cmd_vid,
    input  logic [7:0]    cmd_type,
    input  logic [CW-1:0] cmd_req_cnt,
    input  logic [CW-1:0] cmd_rsp_buf,
    output logic [CW-1:0] req_rd_idx,
    input  logic [31:0]   req_rd_data,
    output logic          rsp_wr_en,
    output logic [CW-1:0] rsp_wr_idx,
    output logic [31:0]   rsp_wr_data,
    output logic          done,
    output logic          err,
    output logic [CW-1:0] rsp_cnt,
    output logic          bus_req,
    output logic          bus_we,
    output logic [1:0]    bus_addr,
    output logic [31:0]   bus_wdata,
    input  logic          bus_ack,
    input  logic [31:0]   bus_rdata
);
    localparam int POLL_RAW = TIMEOUT_CYC / 128;
    localparam int POLL_CYC = (POLL_RAW < 1) ? 1 : POLL_RAW;

    mbx_state_e       state_q;
    logic             dead_q, done_q, err_q;
    logic [CW-1:0]    cnt_q, pay_idx_q, rx_idx_q, req_cnt_q, rsp_buf_q;
    logic [15:0]      vid_q;
    logic [7:0]       type_q;
    logic [LEN_W-1:0] rx_field_q;

    logic             too_long, rx_short, expired, poll_due, tmr_clr, ivl_clr;
    logic [LEN_W-1:0] tx_field;
    logic [CW-1:0]    rx_rem, keep_n;
    logic             st_busy, st_err, st_rdy, hdr_ok, idle_w, last_keep;
    logic             unused_bits;

    assign st_busy     = bus_rdata[STAT_BUSY];
    assign st_err      = bus_rdata[STAT_ERR];
    assign st_rdy      = bus_rdata[STAT_RDY];
    assign hdr_ok      = (bus_rdata[15:0] == vid_q) && (bus_rdata[23:16] == type_q);
    assign idle_w      = (state_q == S_IDLE);
    assign last_keep   = (keep_n != '0) && (rx_idx_q == keep_n - CW'(1));
    assign unused_bits = ^{bus_rdata[30:24], bus_rdata[1]};

    mbx_len #(.LEN_W(LEN_W), .CW(CW)) len_i (
        .req_cnt (req_cnt_q), .rsp_buf (rsp_buf_q), .rx_field(rx_field_q),
        .too_long(too_long),  .tx_field(tx_field),  .rx_short(rx_short),
        .rx_rem  (rx_rem),    .keep_n  (keep_n)
    );

    assign tmr_clr = bus_ack && (state_q == S_GO || state_q == S_AB_WR);
    assign ivl_clr = bus_ack && (state_q == S_POLL_RD || state_q == S_AB_RD
                                 || state_q == S_AB_WR);

    mbx_tmr #(.TIMEOUT_CYC(TIMEOUT_CYC), .POLL_CYC(POLL_CYC)) tmr_i (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .ivl_clr(ivl_clr),
        .expired(expired), .poll_due(poll_due)
    );

    assign done        = done_q;
    assign err         = err_q;
    assign rsp_cnt     = cnt_q;
    assign req_rd_idx  = pay_idx_q;
    assign rsp_wr_en   = (state_q == S_RX_RD) && bus_ack && (rx_idx_q < keep_n);
    assign rsp_wr_idx  = rx_idx_q;
    assign rsp_wr_data = bus_rdata;

    // Bus access implied by the current state; held until acknowledged.
    always_comb begin
        bus_req   = 1'b1;
        bus_we    = 1'b0;
        bus_addr  = A_STAT;
        bus_wdata = '0;
        case (state_q)
            S_PRECHK, S_POLL_RD, S_RX_CHK, S_FIN_RD, S_AB_RD: bus_addr = A_STAT;
            S_HDR1:  begin bus_we = 1'b1; bus_addr = A_WDAT; bus_wdata = {8'h00, type_q, vid_q}; end
            S_HDR2:  begin bus_we = 1'b1; bus_addr = A_WDAT; bus_wdata = 32'(tx_field); end
            S_PAY:   begin bus_we = 1'b1; bus_addr = A_WDAT; bus_wdata = req_rd_data; end
            S_GO:    begin bus_we = 1'b1; bus_addr = A_CTRL; bus_wdata[CTL_GO] = 1'b1; end
            S_AB_WR: begin bus_we = 1'b1; bus_addr = A_CTRL; bus_wdata[CTL_ABORT] = 1'b1; end
            S_RX_H1, S_RX_H2, S_RX_RD: bus_addr = A_RDAT;
            S_RX_A1, S_RX_A2, S_RX_ACK: begin bus_we = 1'b1; bus_addr = A_RDAT; end
            default: bus_req = 1'b0;
        endcase
    end

    // Exchange sequencer: advances on each acknowledged access or timer event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            dead_q     <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            cnt_q      <= '0;
            pay_idx_q  <= '0;
            rx_idx_q   <= '0;
            req_cnt_q  <= '0;
            rsp_buf_q  <= '0;
            vid_q      <= '0;
            type_q     <= '0;
            rx_field_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: if (start) begin
                    vid_q     <= cmd_vid;
                    type_q    <= cmd_type;
                    req_cnt_q <= cmd_req_cnt;
                    rsp_buf_q <= cmd_rsp_buf;
                    pay_idx_q <= '0;
                    rx_idx_q  <= '0;
                    if (dead_q || cmd_rsp_buf == '0) begin
                        done_q <= 1'b1; err_q <= 1'b1; cnt_q <= '0;
                    end else begin
                        state_q <= S_PRECHK;
                    end
                end
                S_PRECHK: if (bus_ack)
                    state_q <= (st_busy || st_err || too_long) ? S_AB_WR : S_HDR1;
                S_HDR1: if (bus_ack) state_q <= S_HDR2;
                S_HDR2: if (bus_ack) state_q <= (req_cnt_q == '0) ? S_GO : S_PAY;
                S_PAY: if (bus_ack) begin
                    pay_idx_q <= pay_idx_q + CW'(1);
                    if (pay_idx_q + CW'(1) == req_cnt_q) state_q <= S_GO;
                end
                S_GO: if (bus_ack) state_q <= S_POLL_RD;
                S_POLL_RD: if (bus_ack) begin
                    if (st_err)       state_q <= S_AB_WR;
                    else if (st_rdy)  state_q <= S_RX_H1;
                    else if (expired) state_q <= S_AB_WR;
                    else              state_q <= S_POLL_WAIT;
                end
                S_POLL_WAIT: if (poll_due) state_q <= S_POLL_RD;
                S_RX_H1: if (bus_ack) state_q <= hdr_ok ? S_RX_A1 : S_AB_WR;
                S_RX_A1: if (bus_ack) state_q <= S_RX_H2;
                S_RX_H2: if (bus_ack) begin
                    rx_field_q <= bus_rdata[LEN_W-1:0];
                    state_q    <= S_RX_A2;
                end
                S_RX_A2: if (bus_ack) begin
                    if (rx_short)           state_q <= S_AB_WR;
                    else if (rx_rem == '0)  state_q <= S_FIN_RD;
                    else                    state_q <= S_RX_RD;
                end
                S_RX_RD:  if (bus_ack) state_q <= last_keep ? S_RX_CHK : S_RX_ACK;
                S_RX_CHK: if (bus_ack) state_q <= st_rdy ? S_RX_ACK : S_AB_WR;
                S_RX_ACK: if (bus_ack) begin
                    rx_idx_q <= rx_idx_q + CW'(1);
                    state_q  <= (rx_idx_q + CW'(1) == rx_rem) ? S_FIN_RD : S_RX_RD;
                end
                S_FIN_RD: if (bus_ack) begin
                    if (st_err) state_q <= S_AB_WR;
                    else begin
                        state_q <= S_IDLE; done_q <= 1'b1; err_q <= 1'b0; cnt_q <= keep_n;
                    end
                end
                S_AB_WR:   if (bus_ack) state_q <= S_AB_WAIT;
                S_AB_WAIT: if (poll_due) state_q <= S_AB_RD;
                S_AB_RD: if (bus_ack) begin
                    if (!st_err && !st_busy) begin
                        state_q <= S_IDLE; done_q <= 1'b1; err_q <= 1'b1; cnt_q <= '0;
                    end else if (expired) begin
                        dead_q  <= 1'b1;
                        state_q <= S_IDLE; done_q <= 1'b1; err_q <= 1'b1; cnt_q <= '0;
                    end else begin
                        state_q <= S_AB_WAIT;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mbx_req_chk.sv
// Protocol checker for the mailbox requester, bound to every instance.
// Assumes idle reflects the sequencer's idle state.
module mbx_req_chk #(
    parameter int CW = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          idle,
    input logic [CW-1:0] cmd_rsp_buf,
    input logic          done,
    input logic          err,
    input logic [CW-1:0] rsp_cnt,
    input logic          rsp_wr_en,
    input logic          bus_req,
    input logic          bus_we,
    input logic [1:0]    bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          bus_ack
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !bus_req);

    // R2
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we)
                               && $stable(bus_addr) && $stable(bus_wdata));

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> idle);

    // R7
    store_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_en |-> bus_req && bus_ack && !bus_we && bus_addr == 2'd3);

    // R12
    buf_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && idle && cmd_rsp_buf == '0 |=> done && err && !bus_req);

    // R13
    err_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && err |-> rsp_cnt == '0);
endmodule

bind mbx_req_engine mbx_req_chk #(.CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .idle(idle_w),
    .cmd_rsp_buf(cmd_rsp_buf), .done(done), .err(err), .rsp_cnt(rsp_cnt),
    .rsp_wr_en(rsp_wr_en), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/mbx_req_engine_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural mailbox responder plus sweeps and corner cases.
module mbx_req_engine_tb_top;
    localparam int LEN_W = 6;
    localparam int TMO   = 256;
    localparam int CW    = LEN_W + 1;
    localparam int MAXL  = 1 << LEN_W;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [15:0] cmd_vid = '0;
    logic [7:0]  cmd_type = '0;
    logic [CW-1:0] cmd_req_cnt = '0, cmd_rsp_buf = '0;
    logic [CW-1:0] req_rd_idx, rsp_wr_idx, rsp_cnt;
    logic [31:0] req_rd_data, rsp_wr_data, bus_wdata, bus_rdata;
    logic rsp_wr_en, done, err, bus_req, bus_we, bus_ack;
    logic [1:0] bus_addr;

    always #2.5 clk = ~clk;

    mbx_req_engine #(.LEN_W(LEN_W), .TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_vid(cmd_vid),
        .cmd_type(cmd_type), .cmd_req_cnt(cmd_req_cnt), .cmd_rsp_buf(cmd_rsp_buf),
        .req_rd_idx(req_rd_idx), .req_rd_data(req_rd_data), .rsp_wr_en(rsp_wr_en),
        .rsp_wr_idx(rsp_wr_idx), .rsp_wr_data(rsp_wr_data), .done(done), .err(err),
        .rsp_cnt(rsp_cnt), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    assign req_rd_data = 32'h5000_0000 | 32'(req_rd_idx);
    assign bus_ack     = bus_req;

    // Responder configuration (written by the tasks only).
    logic c_busy = 0, c_err = 0, c_never = 0, c_abok = 1, c_perr = 0;
    logic c_drop = 0, c_ferr = 0, m_clear = 0;
    int   c_after = 0, total = 0;
    logic [31:0] mem [0:127];

    // Responder state (written by the model only).
    logic [31:0] wlog [0:127];
    logic [31:0] cap  [0:127];
    int nw, go_cnt, ab_cnt, acc_cnt, ptr, polls;
    logic go_seen, ab_clr;
    logic m_err, m_busy, m_rdy;

    always_comb begin
        m_err  = !ab_clr && (c_err || (c_perr && go_seen) || (c_ferr && go_seen && ptr == total));
        m_busy = !ab_clr && c_busy;
        m_rdy  = go_seen && !c_never && polls >= c_after && ptr < total && !(c_drop && ptr >= 2);
        if (bus_addr == 2'd1)      bus_rdata = {m_rdy, 28'h0, m_err, 1'b0, m_busy};
        else if (bus_addr == 2'd3) bus_rdata = (ptr < 128) ? mem[ptr] : 32'h0;
        else                       bus_rdata = 32'h0;
    end

    always @(posedge clk) begin
        if (m_clear) begin
            nw <= 0; go_cnt <= 0; ab_cnt <= 0; acc_cnt <= 0; ptr <= 0; polls <= 0;
            go_seen <= 1'b0; ab_clr <= 1'b0;
        end else if (bus_req) begin
            acc_cnt <= acc_cnt + 1;
            if (bus_we && bus_addr == 2'd2) begin wlog[nw[6:0]] <= bus_wdata; nw <= nw + 1; end
            if (bus_we && bus_addr == 2'd0) begin
                if (bus_wdata[31]) begin go_cnt <= go_cnt + 1; go_seen <= 1'b1; end
                if (bus_wdata[0]) begin ab_cnt <= ab_cnt + 1; if (c_abok) ab_clr <= 1'b1; end
            end
            if (bus_we && bus_addr == 2'd3) ptr <= ptr + 1;
            if (!bus_we && bus_addr == 2'd1 && go_seen) polls <= polls + 1;
        end
        if (rsp_wr_en) cap[rsp_wr_idx] <= rsp_wr_data;
    end

    int nchk = 0, nfail = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg_clean();
        c_busy = 0; c_err = 0; c_never = 0; c_abok = 1; c_perr = 0;
        c_drop = 0; c_ferr = 0; c_after = 0;
    endtask

    // One exchange: response object uses length field fld; payload word k = A000_0000|k.
    task automatic run(input int rq, input int fld, input int bufn, input bit badhdr);
        int len;
        len = (fld == 0) ? MAXL : fld;
        @(negedge clk);
        cmd_vid = 16'hC0DE ^ 16'(rq * 7);
        cmd_type = 8'h10 + 8'(rq);
        cmd_req_cnt = CW'(rq);
        cmd_rsp_buf = CW'(bufn);
        for (int k = 0; k < 128; k++) mem[k] = 32'hA000_0000 | 32'(k);
        mem[0] = {8'h00, cmd_type, cmd_vid} ^ (badhdr ? 32'h0001_0000 : 32'h0);
        mem[1] = 32'(fld);
        total = (len < 2) ? 2 : len;
        m_clear = 1;
        @(negedge clk);
        m_clear = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        cyc = 1;
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        chk(done, "watchdog", 0, 1);
    endtask

    task automatic expect_ok(input int rq, input int fld, input int bufn);
        int len, rem, keep;
        len = (fld == 0) ? MAXL : fld;
        rem = len - 2;
        keep = (rem < bufn) ? rem : bufn;
        chk(err == 0, "R2 err", err, 0);
        chk(rsp_cnt == CW'(keep), "R7 count", rsp_cnt, keep);
        chk(nw == 2 + rq, "R2 writes", nw, 2 + rq);
        chk(wlog[0] == {8'h00, cmd_type, cmd_vid}, "R2 hdr1", wlog[0], {8'h00, cmd_type, cmd_vid});
        chk(wlog[1] == 32'((rq + 2) % MAXL), "R3 hdr2", wlog[1], (rq + 2) % MAXL);
        for (int i = 0; i < rq; i++)
            chk(wlog[2 + i] == (32'h5000_0000 | 32'(i)), "R2 payload", wlog[2 + i], 32'h5000_0000 | i);
        for (int i = 0; i < keep; i++)
            chk(cap[i] == (32'hA000_0000 | 32'(i + 2)), "R2 stored", cap[i], 32'hA000_0000 | (i + 2));
        chk(ptr == len, "R7 drained", ptr, len);
        chk(go_cnt == 1 && ab_cnt == 0, "R2 go/abort", ab_cnt, 0);
    endtask

    task automatic expect_abort(input string tag);
        chk(err == 1, tag, err, 1);
        chk(rsp_cnt == '0, "R13 count", rsp_cnt, 0);
        chk(ab_cnt == 1, tag, ab_cnt, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_req == 0 && done == 0, "R1 reset", {bus_req, done}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(bus_req == 0 && done == 0, "R1 idle", {bus_req, done}, 0);

        // Sweep: request words, response payload, buffer size (R2, R7).
        for (int rq = 0; rq < 4; rq++)
            for (int pl = 0; pl < 6; pl++)
                for (int b = 1; b < 5; b++) begin
                    cfg_clean(); c_after = pl % 3;
                    run(rq, pl + 2, b, 0);
                    expect_ok(rq, pl + 2, b);
                end

        // R3: length of exactly 2^LEN_W goes out as 0.
        cfg_clean(); run(62, 4, 2, 0); expect_ok(62, 4, 2);
        // R3: one beyond the maximum is refused before any header.
        cfg_clean(); run(63, 4, 2, 0); expect_abort("R3 too long");
        chk(nw == 0 && go_cnt == 0, "R3 no header", nw, 0);

        // R4: busy or error at the start.
        cfg_clean(); c_busy = 1; run(1, 4, 2, 0); expect_abort("R4 busy");
        chk(nw == 0, "R4 busy no write", nw, 0);
        cfg_clean(); c_err = 1; run(1, 4, 2, 0); expect_abort("R4 error");
        chk(nw == 0, "R4 error no write", nw, 0);

        // R5: error during polling, then no ready within the timeout.
        cfg_clean(); c_perr = 1; run(1, 4, 2, 0); expect_abort("R5 poll error");
        cfg_clean(); c_never = 1; run(1, 4, 2, 0); expect_abort("R5 timeout");
        chk(cyc >= TMO, "R5 timeout delay", cyc, TMO);
        chk(polls > 8, "R5 poll count", polls, 9);

        // R6: header mismatch.
        cfg_clean(); run(2, 5, 3, 1); expect_abort("R6 header");

        // R8: zero field means maximum; field of 1 is too short.
        cfg_clean(); run(1, 0, 4, 0); expect_ok(1, 0, 4);
        cfg_clean(); run(1, 1, 4, 0); expect_abort("R8 short");

        // R9: ready drops before the last stored acknowledge.
        cfg_clean(); c_drop = 1; run(0, 6, 3, 0); expect_abort("R9 ready lost");
        chk(ptr == 4, "R9 last not acked", ptr, 4);

        // R10: error seen after draining.
        cfg_clean(); c_ferr = 1; run(0, 4, 2, 0); expect_abort("R10 final error");
        chk(ptr == 4, "R10 drained", ptr, 4);

        // R12: zero buffer refused without bus access.
        cfg_clean(); run(1, 4, 0, 0);
        chk(err == 1 && acc_cnt == 0 && cyc == 1, "R12 reject", acc_cnt, 0);

        // R11: abort that never clears makes the engine dead.
        cfg_clean(); c_busy = 1; c_abok = 0; run(1, 4, 2, 0);
        chk(err == 1 && ab_cnt == 1, "R11 abort fail", ab_cnt, 1);
        cfg_clean(); run(1, 4, 2, 0);
        chk(err == 1 && acc_cnt == 0, "R11 dead refuse", acc_cnt, 0);
        cfg_clean(); run(0, 3, 1, 0);
        chk(err == 1 && acc_cnt == 0, "R11 dead again", acc_cnt, 0);
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        cfg_clean(); run(2, 5, 2, 0); expect_ok(2, 5, 2);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule